// File: doc/BRIEF.md
# Performance-Monitor User Access Gate

This block holds the small user-access control register of a performance-monitor unit. For every system-register access request it decides, in the same cycle, whether the access completes, traps to a higher privilege level, or is undefined. It gives each access a target-register class, a privilege level from 0 to 3 and a direction. The hypervisor-level and monitor-level trap-enable bits, together with the presence flags for those levels, are inputs from the rest of the core.

At level 0 the register's master enable opens user access to the whole monitor. Three override bits each open one narrow path while the master enable is clear: event-counter reads and select-register access, cycle-counter reads, and software-increment writes. When the level-0 policy lets an access through, the higher-level trap checks follow in a fixed order. From levels 0 and 1 the hypervisor check comes first and the monitor check second. From level 2 only the monitor check applies. Level 3 never traps. The register is written only by an allowed write from level 1 or above, and it is read back through the same request path.

Top module: `pmu_user_gate`

## Requirements
- R1: After reset, all four register bits are zero. A level-3 read of class 0 is allowed and returns 0.
- R2: The register keeps write-data bits [3:0]. These are bit 3 (event-read override), bit 2 (cycle-read override), bit 1 (increment-write override) and bit 0 (master enable). An allowed write to class 0 updates it at the next clock edge. A write that is not allowed leaves it unchanged. An allowed read of class 0 returns the register zero-extended, with bits [63:4] zero. Any other request returns 0 on the read data.
- R3: While a request is valid, exactly one of allow, trap and undefined is high. With no request, all three are low.
- R4: At level 0 the bench targets class 1 (event counter, direct or indirect) and class 2 (counter select). A class-1 read, or a class-2 read or write, is allowed by the level-0 policy when bit 3 or bit 0 is set. A class-1 write needs bit 0. Otherwise the access traps to level 1.
- R5: At level 0, a class-3 read (cycle counter) passes when bit 2 or bit 0 is set. A class-3 write needs bit 0. Otherwise the access traps to level 1.
- R6: At level 0, a class-4 write (software increment) passes when bit 1 or bit 0 is set. A class-4 read needs bit 0. Otherwise the access traps to level 1.
- R7: At level 0, class 5 (interrupt-enable set/clear) always traps to level 1, whatever the register holds. Classes 6 to 15 (other monitor registers) pass only when bit 0 is set.
- R8: At level 0, a write to class 0 (this register) is undefined and takes no trap. A read of class 0 passes the level-0 policy.
- R9: At levels 0 and 1 the checks run in order. If the hypervisor level is enabled and its trap bit is set, the access traps to level 2. Otherwise, if the monitor level is present and its trap bit is set, the access traps to level 3. Otherwise the access is allowed. A disabled or absent level skips its check.
- R10: At level 2 only the monitor check applies. At level 3 every request is allowed.
- R11: Every trap reports syndrome class 0x18, and the syndrome is 0 otherwise. The trap level is always above the current level.
- R12: A level-0 policy denial traps to level 1, even when the hypervisor or monitor trap bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present |
| cur_lvl_i | input | 2 | Current privilege level |
| wr_i | input | 1 | 1 = write, 0 = read |
| cls_i | input | 4 | Target-register class code |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_trap_i | input | 1 | Hypervisor monitor-trap bit |
| mon_present_i | input | 1 | Monitor level present |
| mon_trap_i | input | 1 | Monitor-level monitor-trap bit |
| wdata_i | input | 64 | Write data |
| allow_o | output | 1 | Access completes |
| trap_o | output | 1 | Access traps |
| trap_lvl_o | output | 2 | Level the trap goes to |
| undef_o | output | 1 | Access is undefined |
| syn_cls_o | output | 6 | Syndrome class code |
| rdata_o | output | 64 | Read data |

## Verification
The bench goes after three kinds of mistake.

- A design that lets an override bit open the wrong direction would allow a level-0 event-counter write or cycle-counter write without the master enable.
- A design that runs the higher-level checks ahead of the level-0 policy would send a user denial to level 2 or 3. One that ignores the presence flags would trap to a level that does not exist.
- A level-0 write of the register itself must come out undefined and leave the stored bits untouched. Interrupt-enable accesses must trap even with every bit set.

The directed cases cover each of these. The random mix covers the other combinations of level, class and register content.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned CLS_W = 4;
  localparam int unsigned SYN_W = 6;
  localparam int unsigned UEN_W = 4;
  localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

  localparam logic [CLS_W-1:0] CLS_USER_EN = 4'd0;
  localparam logic [CLS_W-1:0] CLS_EVT_CNT = 4'd1;
  localparam logic [CLS_W-1:0] CLS_CNT_SEL = 4'd2;
  localparam logic [CLS_W-1:0] CLS_CYC_CNT = 4'd3;
  localparam logic [CLS_W-1:0] CLS_SW_INC  = 4'd4;
  localparam logic [CLS_W-1:0] CLS_INT_EN  = 4'd5;

  typedef struct packed {
    logic evt_rd;    // bit 3
    logic cyc_rd;    // bit 2
    logic inc_wr;    // bit 1
    logic master;    // bit 0
  } uen_t;

  typedef struct packed {
    logic             allow;
    logic             trap;
    logic [LVL_W-1:0] lvl;
    logic             undef;
  } verdict_t;
endpackage

// File: rtl/pmu_user_reg.sv
module pmu_user_reg
  import pmu_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [UEN_W-1:0]  wdata_i,
  output uen_t              q_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - UEN_W;

  uen_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= uen_t'(wdata_i);
  end

  assign q_o = q;
  assign rdata_o[UEN_W-1:0] = q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o[DATA_W-1:UEN_W] = '0;
    end
  endgenerate
endmodule

// File: rtl/pmu_lvl0_policy.sv
module pmu_lvl0_policy
  import pmu_gate_pkg::*;
(
  input  uen_t             uen_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             wr_i,
  output logic             pass_o,
  output logic             undef_o
);
  always_comb begin
    undef_o = 1'b0;
    unique case (cls_i)
      CLS_USER_EN: begin
        pass_o  = !wr_i;
        undef_o = wr_i;
      end
      CLS_EVT_CNT: pass_o = uen_i.master | (!wr_i & uen_i.evt_rd);
      CLS_CNT_SEL: pass_o = uen_i.master | uen_i.evt_rd;
      CLS_CYC_CNT: pass_o = uen_i.master | (!wr_i & uen_i.cyc_rd);
      CLS_SW_INC:  pass_o = uen_i.master | (wr_i & uen_i.inc_wr);
      CLS_INT_EN:  pass_o = 1'b0;
      default:     pass_o = uen_i.master;
    endcase
  end
endmodule

// File: rtl/pmu_upper_trap.sv
module pmu_upper_trap
  import pmu_gate_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             hyp_en_i,
  input  logic             hyp_trap_i,
  input  logic             mon_present_i,
  input  logic             mon_trap_i,
  output logic             trap_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic hyp_hit, mon_hit;

  assign hyp_hit = (cur_lvl_i < 2'd2) & hyp_en_i & hyp_trap_i;
  assign mon_hit = (cur_lvl_i < 2'd3) & mon_present_i & mon_trap_i;

  always_comb begin
    trap_o = 1'b0;
    lvl_o  = '0;
    if (hyp_hit) begin
      trap_o = 1'b1;
      lvl_o  = 2'd2;
    end else if (mon_hit) begin
      trap_o = 1'b1;
      lvl_o  = 2'd3;
    end
  end
endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        cur_lvl_i,
  input  logic              wr_i,
  input  logic [3:0]        cls_i,
  input  logic              hyp_en_i,
  input  logic              hyp_trap_i,
  input  logic              mon_present_i,
  input  logic              mon_trap_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              allow_o,
  output logic              trap_o,
  output logic [1:0]        trap_lvl_o,
  output logic              undef_o,
  output logic [5:0]        syn_cls_o,
  output logic [DATA_W-1:0] rdata_o
);
  uen_t             uen_q;
  logic [DATA_W-1:0] reg_rdata;
  logic             l0_pass, l0_undef;
  logic             up_trap;
  logic [LVL_W-1:0] up_lvl;
  logic             uen_we, hit_self;
  verdict_t         v;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:UEN_W];
  assign hit_self  = (cls_i == CLS_USER_EN);
  assign uen_we    = req_valid_i & wr_i & v.allow & hit_self;

  pmu_user_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (uen_we),
    .wdata_i (wdata_i[UEN_W-1:0]),
    .q_o     (uen_q),
    .rdata_o (reg_rdata)
  );

  pmu_lvl0_policy u_l0 (
    .uen_i   (uen_q),
    .cls_i   (cls_i),
    .wr_i    (wr_i),
    .pass_o  (l0_pass),
    .undef_o (l0_undef)
  );

  pmu_upper_trap u_up (
    .cur_lvl_i     (cur_lvl_i),
    .hyp_en_i      (hyp_en_i),
    .hyp_trap_i    (hyp_trap_i),
    .mon_present_i (mon_present_i),
    .mon_trap_i    (mon_trap_i),
    .trap_o        (up_trap),
    .lvl_o         (up_lvl)
  );

  // level-0 policy outranks the higher-level checks
  always_comb begin
    v = '0;
    if (req_valid_i) begin
      if (cur_lvl_i == 2'd0 && l0_undef) begin
        v.undef = 1'b1;
      end else if (cur_lvl_i == 2'd0 && !l0_pass) begin
        v.trap = 1'b1;
        v.lvl  = 2'd1;
      end else if (up_trap) begin
        v.trap = 1'b1;
        v.lvl  = up_lvl;
      end else begin
        v.allow = 1'b1;
      end
    end
  end

  assign allow_o    = v.allow;
  assign trap_o     = v.trap;
  assign trap_lvl_o = v.lvl;
  assign undef_o    = v.undef;
  assign syn_cls_o  = v.trap ? SYN_SYSREG : '0;
  assign rdata_o    = (v.allow && !wr_i && hit_self) ? reg_rdata : '0;
endmodule

// File: rtl/pmu_user_gate_chk.sv
module pmu_user_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] cur_lvl_i,
  input logic       wr_i,
  input logic [3:0] cls_i,
  input logic [3:0] wdata_lo,
  input logic       allow_o,
  input logic       trap_o,
  input logic [1:0] trap_lvl_o,
  input logic       undef_o,
  input logic [5:0] syn_cls_o,
  input logic [3:0] rdata_hi_or,
  input logic [3:0] uen_q
);
  logic self_wr;
  assign self_wr = req_valid_i && wr_i && allow_o && cls_i == 4'd0;

  p_one_outcome_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({allow_o, trap_o, undef_o}) == 1);
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(allow_o || trap_o || undef_o));
  p_self_wr_undef_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cur_lvl_i == 2'd0 && wr_i && cls_i == 4'd0) |-> undef_o);
  p_int_en_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cur_lvl_i == 2'd0 && cls_i == 4'd5) |-> (trap_o && trap_lvl_o == 2'd1));
  p_top_lvl_allow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cur_lvl_i == 2'd3) |-> allow_o);
  p_syn_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> syn_cls_o == 6'h18);
  p_trap_above_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_lvl_o > cur_lvl_i);
  p_wr_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_wr |=> uen_q == $past(wdata_lo));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !self_wr |=> $stable(uen_q));
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_hi_or == 4'd0);
endmodule

bind pmu_user_gate pmu_user_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .cur_lvl_i   (cur_lvl_i),
  .wr_i        (wr_i),
  .cls_i       (cls_i),
  .wdata_lo    (wdata_i[3:0]),
  .allow_o     (allow_o),
  .trap_o      (trap_o),
  .trap_lvl_o  (trap_lvl_o),
  .undef_o     (undef_o),
  .syn_cls_o   (syn_cls_o),
  .rdata_hi_or ({|rdata_o[63:48], |rdata_o[47:32], |rdata_o[31:16], |rdata_o[15:4]}),
  .uen_q       (uen_q)
);

// File: tb/sim_pmu_user_gate.sv
`timescale 1ns/100ps
module sim_pmu_user_gate;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  cur_lvl_i = '0;
  logic [3:0]  cls_i = '0;
  logic        hyp_en_i = 1'b0, hyp_trap_i = 1'b0, mon_present_i = 1'b0, mon_trap_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic        allow_o, trap_o, undef_o;
  logic [1:0]  trap_lvl_o;
  logic [5:0]  syn_cls_o;
  logic [63:0] rdata_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  logic [3:0] model = 4'd0;

  always #2.5 clk_i = ~clk_i;

  pmu_user_gate u0 (.*);

  function automatic logic [4:0] expect_v(input logic [1:0] lvl, input logic wr,
      input logic [3:0] cls, input logic [3:0] m, input logic he, ht, mp, mt);
    logic ok;
    if (lvl == 2'd0) begin
      case (cls)
        4'd0: begin if (wr) return 5'b00001; ok = 1'b1; end
        4'd1: ok = wr ? m[0] : (m[3] | m[0]);
        4'd2: ok = m[3] | m[0];
        4'd3: ok = wr ? m[0] : (m[2] | m[0]);
        4'd4: ok = wr ? (m[1] | m[0]) : m[0];
        4'd5: ok = 1'b0;
        default: ok = m[0];
      endcase
      if (!ok) return 5'b01010;
    end
    if (lvl <= 2'd1 && he && ht) return 5'b01100;
    if (lvl <= 2'd2 && mp && mt) return 5'b01110;
    return 5'b10000;
  endfunction

  function automatic string tag_of(input logic [1:0] lvl, input logic [3:0] cls);
    if (lvl == 2'd1) return "R9";
    if (lvl >= 2'd2) return "R10";
    case (cls)
      4'd0: return "R8";
      4'd1, 4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input string tag, input logic [1:0] lvl, input logic wr,
      input logic [3:0] cls, input logic he, ht, mp, mt, input logic [63:0] wd);
    logic [4:0] e;
    @(negedge clk_i);
    req_valid_i = 1'b1; cur_lvl_i = lvl; wr_i = wr; cls_i = cls;
    hyp_en_i = he; hyp_trap_i = ht; mon_present_i = mp; mon_trap_i = mt; wdata_i = wd;
    #1;
    e = expect_v(lvl, wr, cls, model, he, ht, mp, mt);
    check(tag, {59'd0, allow_o, trap_o, trap_lvl_o, undef_o}, {59'd0, e});
    check("R11", {58'd0, syn_cls_o}, {58'd0, (e[3] ? 6'h18 : 6'h00)});
    check("R2", rdata_o, (e[4] && !wr && cls == 4'd0) ? {60'd0, model} : 64'd0);
    @(posedge clk_i);
    if (e[4] && wr && cls == 4'd0) model = wd[3:0];
  endtask

  task automatic do_idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; wr_i = 1'b1; cls_i = 4'd0; cur_lvl_i = 2'd3; #1;
    check("R3", {61'd0, allow_o, trap_o, undef_o}, 64'd0);
    @(posedge clk_i);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    do_req("R1", 2'd3, 1'b0, 4'd0, 0, 0, 0, 0, 64'd0);
    do_idle();
    do_req("R2", 2'd3, 1'b1, 4'd0, 1, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFF5);
    do_req("R2", 2'd3, 1'b0, 4'd0, 0, 0, 0, 0, 64'd0);
    do_req("R2", 2'd1, 1'b1, 4'd0, 1, 1, 0, 0, 64'h0F);
    do_req("R2", 2'd2, 1'b0, 4'd0, 0, 0, 0, 0, 64'd0);
    do_req("R8", 2'd0, 1'b1, 4'd0, 0, 0, 0, 0, 64'h0A);
    do_req("R8", 2'd0, 1'b0, 4'd0, 0, 0, 0, 0, 64'd0);
    do_req("R7", 2'd0, 1'b0, 4'd5, 0, 0, 0, 0, 64'd0);
    do_req("R9", 2'd1, 1'b0, 4'd0, 0, 1, 1, 1, 64'd0);
    do_req("R9", 2'd1, 1'b0, 4'd0, 1, 1, 0, 1, 64'd0);
    do_req("R10", 2'd2, 1'b0, 4'd0, 1, 1, 0, 1, 64'd0);
    do_req("R10", 2'd2, 1'b0, 4'd0, 1, 1, 1, 1, 64'd0);
    do_req("R2", 2'd1, 1'b1, 4'd0, 0, 0, 0, 0, 64'h8);
    do_req("R4", 2'd0, 1'b1, 4'd1, 0, 0, 0, 0, 64'd0);
    do_req("R4", 2'd0, 1'b0, 4'd1, 0, 0, 0, 0, 64'd0);
    do_req("R4", 2'd0, 1'b1, 4'd2, 0, 0, 0, 0, 64'd0);
    do_req("R5", 2'd0, 1'b0, 4'd3, 0, 0, 0, 0, 64'd0);
    do_req("R6", 2'd0, 1'b1, 4'd4, 0, 0, 0, 0, 64'd0);
    do_req("R12", 2'd0, 1'b0, 4'd3, 1, 1, 1, 1, 64'd0);
    do_req("R12", 2'd0, 1'b0, 4'd1, 1, 1, 1, 1, 64'd0);
    do_req("R2", 2'd1, 1'b1, 4'd0, 0, 0, 0, 0, 64'h6);
    do_req("R5", 2'd0, 1'b0, 4'd3, 0, 0, 0, 0, 64'd0);
    do_req("R5", 2'd0, 1'b1, 4'd3, 0, 0, 0, 0, 64'd0);
    do_req("R6", 2'd0, 1'b1, 4'd4, 0, 0, 0, 0, 64'd0);
    do_req("R6", 2'd0, 1'b0, 4'd4, 0, 0, 0, 0, 64'd0);
    do_req("R7", 2'd0, 1'b0, 4'd9, 0, 0, 0, 0, 64'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] lvl;
      logic [3:0] cls;
      lvl = 2'($urandom_range(0, 3));
      cls = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 9));
      if ($urandom_range(0, 7) == 0) do_idle();
      do_req(tag_of(lvl, cls), lvl, 1'($urandom), cls,
             1'($urandom), ($urandom_range(0, 3) == 0), 1'($urandom),
             ($urandom_range(0, 3) == 0), {$urandom, $urandom});
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule